// File: doc/BRIEF.md
# Dual-clock FIFO with block retransmit

This block is a single-direction word buffer between two clock domains that have no fixed relation to each other. A producer pushes words through the write port on its own clock. A consumer pulls them through the read port on another clock. Each port has an enable and a request input. An access takes place only when both are high at a rising edge of that port's clock and the buffer can take it: a write needs free space and a read needs stored data. The port then raises its acknowledge for the following cycle. A producer or consumer that does not use the handshake ties the request high and watches the flags instead.

Each side reports five fill flags from its own view of the occupancy. The almost-empty and almost-full thresholds are registers on each side, loadable at run time. Both come out of reset at 8, so the buffer works without any set-up. The read port can mark its current position and later jump back to it. Everything read since the mark is then replayed, as often as needed. The words behind the mark stay protected from overwriting until the mark is released. Pointers cross between domains in Gray code through synchronizer chains.

Top module: `xrf_fifo`

## Requirements
- R1: After reset both flag vectors read 5'b00011 (empty and almost-empty), both acknowledges are low, the read data is zero and both thresholds on both sides are 8.
- R2: A write is taken when wr_en and wr_req are high at a wclk edge and the write side is not full. wr_ack is high for the cycle after that edge exactly when the write was taken. While full, a write is refused and leaves the stored words unchanged.
- R3: A read is taken when rd_en and rd_req are high at an rclk edge and the read side is not empty. rd_data and rd_ack change at that same edge, and words come out in write order. While empty, a read is refused and rd_ack stays low.
- R4: With the port enable low, a high request does nothing: there is no acknowledge and no pointer moves.
- R5: Flag vectors are packed as bit 4 full, bit 3 almost-full, bit 2 half-full, bit 1 almost-empty, bit 0 empty. For a level L on a depth of 256: empty is L==0, almost-empty is L<=AE, half-full is L>=128, almost-full is L>=256-AF, and full is L==256.
- R6: The write-side level counts words written minus words freed. The read-side level counts the writes seen minus words read. A write shows on the read flags by the fourth rclk edge after it, and both sides agree once traffic stops.
- R7: A threshold load at an edge with thr_we high sets the almost-empty threshold (thr_sel 0) or the almost-full threshold (thr_sel 1) of that side to thr_val (0 to 256). The new value acts from the next cycle.
- R8: A rd_mark pulse saves the current read position and makes the mark active. While the mark is active, reads do not free write-side space at or beyond the mark.
- R9: A rd_retx pulse with an active mark sets the read position back to the mark, so later reads replay the block from there. A read requested in that cycle is refused. It can be repeated any number of times.
- R10: rd_retx with no active mark has no effect on the read position.
- R11: A rd_release pulse ends the mark. The write side then regains the space of the words already read.
- R12: A pointer that crosses to the other domain advances by at most one step per source cycle, so its Gray code changes by at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write port enable |
| wr_req | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_ack | output | 1 | Write taken in the previous cycle |
| wr_thr_we | input | 1 | Load a write-side threshold |
| wr_thr_sel | input | 1 | 0 almost-empty, 1 almost-full |
| wr_thr_val | input | 9 | Threshold value |
| wr_flags | output | 5 | Write-side flags {full, almost-full, half, almost-empty, empty} |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read port enable |
| rd_req | input | 1 | Read request |
| rd_data | output | 36 | Last word read |
| rd_ack | output | 1 | Read taken in the previous cycle |
| rd_mark | input | 1 | Save the read position as the mark |
| rd_release | input | 1 | End the mark |
| rd_retx | input | 1 | Return the read position to the mark |
| rd_thr_we | input | 1 | Load a read-side threshold |
| rd_thr_sel | input | 1 | 0 almost-empty, 1 almost-full |
| rd_thr_val | input | 9 | Threshold value |
| rd_flags | output | 5 | Read-side flags, same packing as wr_flags |

## Verification
Acknowledges, read data and the flags of the same side are due at the edge that samples the access. The bench therefore drives on the falling edge and samples 1 ns after the next rising edge of that port's clock. A change crossing domains is due on the other side's flags within four edges of the receiving clock. One directed check samples there. Every other flag check first waits eight edges of both clocks, so that both views have settled before the comparison.

// File: rtl/xrf_pkg.sv
`timescale 1ns/1ps
package xrf_pkg;
   localparam int FLG_W      = 5;
   localparam int FLG_EMPTY  = 0;
   localparam int FLG_AEMPTY = 1;
   localparam int FLG_HALF   = 2;
   localparam int FLG_AFULL  = 3;
   localparam int FLG_FULL   = 4;

   typedef enum logic {
      THR_AEMPTY = 1'b0,
      THR_AFULL  = 1'b1
   } thr_sel_e;
endpackage

// File: rtl/xrf_ptr_cross.sv
`timescale 1ns/1ps
module xrf_ptr_cross #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_bin,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_bin
);
   logic [W-1:0]             src_gray_q;
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xrf_ptr_cross: at least two synchronizer stages needed");
      end
      if (W < 2) begin : g_bad_width
         $error("xrf_ptr_cross: pointer width too small");
      end
   endgenerate

   function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
      logic [W-1:0] b;
      b[W-1] = g[W-1];
      for (int i = W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) src_gray_q <= '0;
      else            src_gray_q <= src_bin ^ (src_bin >> 1);
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) chain_q <= '0;
      else            chain_q <= {chain_q[STAGES-2:0], src_gray_q};
   end

   assign dst_bin = gray_to_bin(chain_q[STAGES-1]);

   // R12: the exported code never changes by more than one bit per cycle
   p_gray_onebit_r12: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      $countones(src_gray_q ^ $past(src_gray_q)) <= 1);
endmodule

// File: rtl/xrf_level_flags.sv
`timescale 1ns/1ps
module xrf_level_flags import xrf_pkg::*; #(
   parameter int AW      = 8,
   parameter int DEF_THR = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_we,
   input  logic             thr_sel,
   input  logic [AW:0]      thr_val,
   input  logic [AW:0]      level,
   output logic [FLG_W-1:0] flags
);
   localparam int          DEPTH    = 1 << AW;
   localparam logic [AW:0] LVL_FULL = DEPTH[AW:0];
   localparam logic [AW:0] LVL_HALF = LVL_FULL >> 1;
   localparam logic [AW:0] THR_RST  = DEF_THR[AW:0];

   logic [AW:0]   ae_thr_q;
   logic [AW:0]   af_thr_q;
   logic [AW+1:0] af_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_thr_q <= THR_RST;
         af_thr_q <= THR_RST;
      end else if (thr_we) begin
         if (thr_sel == THR_AFULL) af_thr_q <= thr_val;
         else                      ae_thr_q <= thr_val;
      end
   end

   assign af_sum = {1'b0, level} + {1'b0, af_thr_q};

   always_comb begin
      flags             = '0;
      flags[FLG_EMPTY]  = (level == '0);
      flags[FLG_AEMPTY] = (level <= ae_thr_q);
      flags[FLG_HALF]   = (level >= LVL_HALF);
      flags[FLG_AFULL]  = (af_sum >= {1'b0, LVL_FULL});
      flags[FLG_FULL]   = (level == LVL_FULL);
   end

   // R6: the level seen from either side never exceeds the depth
   p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_FULL);
endmodule

// File: rtl/xrf_wr_port.sv
`timescale 1ns/1ps
module xrf_wr_port import xrf_pkg::*; #(
   parameter int AW      = 8,
   parameter int DEF_THR = 8
) (
   input  logic             wclk,
   input  logic             wrst_n,
   input  logic             wen,
   input  logic             wreq,
   input  logic             thr_we,
   input  logic             thr_sel,
   input  logic [AW:0]      thr_val,
   input  logic [AW:0]      base_sync,
   output logic             wack,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [AW:0]      wptr,
   output logic [FLG_W-1:0] flags
);
   logic [AW:0] wptr_q;
   logic [AW:0] level;
   logic        accept;
   logic        ack_q;

   assign level = wptr_q - base_sync;

   xrf_level_flags #(.AW(AW), .DEF_THR(DEF_THR)) u_flags (
      .clk     (wclk),
      .rst_n   (wrst_n),
      .thr_we  (thr_we),
      .thr_sel (thr_sel),
      .thr_val (thr_val),
      .level   (level),
      .flags   (flags)
   );

   assign accept = wen & wreq & ~flags[FLG_FULL];

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wptr_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         wptr_q <= wptr_q + (AW+1)'(accept);
         ack_q  <= accept;
      end
   end

   assign wack     = ack_q;
   assign mem_we   = accept;
   assign mem_addr = wptr_q[AW-1:0];
   assign wptr     = wptr_q;

   // R2: an acknowledge answers a request sampled with the port enabled
   p_wack_req_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
      wack |-> $past(wen && wreq));

   // R4: with the enable low the write pointer holds
   p_wr_disabled_hold_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
      !wen |=> (wptr_q == $past(wptr_q)));
endmodule

// File: rtl/xrf_rd_port.sv
`timescale 1ns/1ps
module xrf_rd_port import xrf_pkg::*; #(
   parameter int AW      = 8,
   parameter int DEF_THR = 8
) (
   input  logic             rclk,
   input  logic             rrst_n,
   input  logic             ren,
   input  logic             rreq,
   input  logic             rmark,
   input  logic             rrelease,
   input  logic             rretx,
   input  logic             thr_we,
   input  logic             thr_sel,
   input  logic [AW:0]      thr_val,
   input  logic [AW:0]      wptr_sync,
   output logic             rack,
   output logic             mem_re,
   output logic [AW-1:0]    mem_raddr,
   output logic [AW:0]      base_ptr,
   output logic [FLG_W-1:0] flags
);
   logic [AW:0] rptr_q;
   logic [AW:0] mark_q;
   logic        mark_on_q;
   logic [AW:0] base_q;
   logic [AW:0] base_target;
   logic [AW:0] level;
   logic        retx_eff;
   logic        accept;
   logic        ack_q;

   assign level = wptr_sync - rptr_q;

   xrf_level_flags #(.AW(AW), .DEF_THR(DEF_THR)) u_flags (
      .clk     (rclk),
      .rst_n   (rrst_n),
      .thr_we  (thr_we),
      .thr_sel (thr_sel),
      .thr_val (thr_val),
      .level   (level),
      .flags   (flags)
   );

   assign retx_eff    = rretx & mark_on_q;
   assign accept      = ren & rreq & ~flags[FLG_EMPTY] & ~retx_eff;
   assign base_target = mark_on_q ? mark_q : rptr_q;

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rptr_q    <= '0;
         mark_q    <= '0;
         mark_on_q <= 1'b0;
         base_q    <= '0;
         ack_q     <= 1'b0;
      end else begin
         ack_q <= accept;
         if (retx_eff)    rptr_q <= mark_q;
         else if (accept) rptr_q <= rptr_q + 1'b1;
         if (!retx_eff) begin
            if (rmark) begin
               mark_q    <= rptr_q;
               mark_on_q <= 1'b1;
            end else if (rrelease) begin
               mark_on_q <= 1'b0;
            end
         end
         if (base_q != base_target) base_q <= base_q + 1'b1;
      end
   end

   assign rack      = ack_q;
   assign mem_re    = accept;
   assign mem_raddr = rptr_q[AW-1:0];
   assign base_ptr  = base_q;

   // R3: an acknowledge answers a request sampled with the port enabled
   p_rack_req_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
      rack |-> $past(ren && rreq));

   // R9: retransmit with a live mark lands the read pointer on the mark
   p_retx_restore_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rretx && mark_on_q) |=> (rptr_q == $past(mark_q)));

   // R11: freed space is handed over one word per cycle at most
   p_base_step_r11: assert property (@(posedge rclk) disable iff (!rrst_n)
      (AW+1)'(base_q - $past(base_q)) <= (AW+1)'(1));

   // R10: retransmit without a mark leaves the pointer to normal reads
   p_retx_nomark_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rretx && !mark_on_q && !accept) |=> (rptr_q == $past(rptr_q)));
endmodule

// File: rtl/xrf_fifo.sv
`timescale 1ns/1ps
module xrf_fifo import xrf_pkg::*; #(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_THR     = 8
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_en,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack,
   input  logic              wr_thr_we,
   input  logic              wr_thr_sel,
   input  logic [ADDR_W:0]   wr_thr_val,
   output logic [FLG_W-1:0]  wr_flags,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ack,
   input  logic              rd_mark,
   input  logic              rd_release,
   input  logic              rd_retx,
   input  logic              rd_thr_we,
   input  logic              rd_thr_sel,
   input  logic [ADDR_W:0]   rd_thr_val,
   output logic [FLG_W-1:0]  rd_flags
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("xrf_fifo: ADDR_W out of range");
      end
      if (DEF_THR < 0 || DEF_THR > DEPTH) begin : g_bad_thr
         $error("xrf_fifo: DEF_THR must lie within the depth");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xrf_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rdata_q;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic              mem_re;
   logic [ADDR_W-1:0] mem_raddr;
   logic [PW-1:0]     wptr;
   logic [PW-1:0]     wptr_sync;
   logic [PW-1:0]     base_ptr;
   logic [PW-1:0]     base_sync;

   xrf_wr_port #(.AW(ADDR_W), .DEF_THR(DEF_THR)) u_wr (
      .wclk      (wclk),
      .wrst_n    (wrst_n),
      .wen       (wr_en),
      .wreq      (wr_req),
      .thr_we    (wr_thr_we),
      .thr_sel   (wr_thr_sel),
      .thr_val   (wr_thr_val),
      .base_sync (base_sync),
      .wack      (wr_ack),
      .mem_we    (mem_we),
      .mem_addr  (mem_waddr),
      .wptr      (wptr),
      .flags     (wr_flags)
   );

   xrf_rd_port #(.AW(ADDR_W), .DEF_THR(DEF_THR)) u_rd (
      .rclk      (rclk),
      .rrst_n    (rrst_n),
      .ren       (rd_en),
      .rreq      (rd_req),
      .rmark     (rd_mark),
      .rrelease  (rd_release),
      .rretx     (rd_retx),
      .thr_we    (rd_thr_we),
      .thr_sel   (rd_thr_sel),
      .thr_val   (rd_thr_val),
      .wptr_sync (wptr_sync),
      .rack      (rd_ack),
      .mem_re    (mem_re),
      .mem_raddr (mem_raddr),
      .base_ptr  (base_ptr),
      .flags     (rd_flags)
   );

   xrf_ptr_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_x (
      .src_clk   (wclk),
      .src_rst_n (wrst_n),
      .src_bin   (wptr),
      .dst_clk   (rclk),
      .dst_rst_n (rrst_n),
      .dst_bin   (wptr_sync)
   );

   xrf_ptr_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_base_x (
      .src_clk   (rclk),
      .src_rst_n (rrst_n),
      .src_bin   (base_ptr),
      .dst_clk   (wclk),
      .dst_rst_n (wrst_n),
      .dst_bin   (base_sync)
   );

   always_ff @(posedge wclk) begin
      if (mem_we) mem_q[mem_waddr] <= wr_data;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n)     rdata_q <= '0;
      else if (mem_re) rdata_q <= mem_q[mem_raddr];
   end

   assign rd_data = rdata_q;

   // R3: read data only moves on an accepted read
   p_rdata_hold_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
      !rd_ack |-> $stable(rd_data));
endmodule

// File: tb/tb_xrf_fifo.sv
`timescale 1ns/1ps
module tb_xrf_fifo;
   logic        wclk, wrst_n, wr_en, wr_req, wr_thr_we, wr_thr_sel;
   logic [35:0] wr_data;
   logic [8:0]  wr_thr_val;
   logic        wr_ack;
   logic [4:0]  wr_flags;
   logic        rclk, rrst_n, rd_en, rd_req, rd_mark, rd_release, rd_retx;
   logic        rd_thr_we, rd_thr_sel;
   logic [8:0]  rd_thr_val;
   logic [35:0] rd_data;
   logic        rd_ack;
   logic [4:0]  rd_flags;

   int errors = 0;
   int checks = 0;
   int widx   = 0;
   int ridx   = 0;
   int mark_idx = 0;
   bit done   = 0;

   xrf_fifo dut (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_req(wr_req),
      .wr_data(wr_data), .wr_ack(wr_ack), .wr_thr_we(wr_thr_we),
      .wr_thr_sel(wr_thr_sel), .wr_thr_val(wr_thr_val), .wr_flags(wr_flags),
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_req(rd_req),
      .rd_data(rd_data), .rd_ack(rd_ack), .rd_mark(rd_mark),
      .rd_release(rd_release), .rd_retx(rd_retx), .rd_thr_we(rd_thr_we),
      .rd_thr_sel(rd_thr_sel), .rd_thr_val(rd_thr_val), .rd_flags(rd_flags)
   );

   initial begin
      wclk = 0;
      forever #5 wclk = ~wclk;
   end
   initial begin
      rclk = 0;
      #2;
      forever #5 rclk = ~rclk;
   end

   // level (9 bits) and the expected flags (5 bits), same on both sides
   localparam int LV_N = 12;
   localparam logic [13:0] LV_TAB [LV_N] = '{
      {9'd1,   5'b00010}, {9'd8,   5'b00010}, {9'd9,   5'b00000},
      {9'd127, 5'b00000}, {9'd128, 5'b00100}, {9'd247, 5'b00100},
      {9'd248, 5'b01100}, {9'd255, 5'b01100}, {9'd256, 5'b11100},
      {9'd100, 5'b00000}, {9'd8,   5'b00010}, {9'd0,   5'b00011}
   };

   function automatic logic [35:0] pat(input int i);
      return {4'hA, i[15:0], ~i[15:0]};
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_word(input bit ok, input string tag);
      @(negedge wclk);
      wr_en = 1; wr_req = 1; wr_data = pat(widx);
      @(posedge wclk); #1;
      wr_en = 0; wr_req = 0;
      chk(tag, {35'd0, wr_ack}, {35'd0, ok});
      if (ok) widx++;
   endtask

   task automatic rd_word(input bit ok, input string tag);
      @(negedge rclk);
      rd_en = 1; rd_req = 1;
      @(posedge rclk); #1;
      rd_en = 0; rd_req = 0;
      chk(tag, {35'd0, rd_ack}, {35'd0, ok});
      if (ok) begin
         chk({tag, " data"}, rd_data, pat(ridx));
         ridx++;
      end
   endtask

   task automatic rd_ctl(input int which);
      @(negedge rclk);
      if (which == 0) rd_mark = 1;
      else if (which == 1) rd_release = 1;
      else rd_retx = 1;
      @(posedge rclk); #1;
      rd_mark = 0; rd_release = 0; rd_retx = 0;
   endtask

   task automatic settle();
      repeat (8) @(posedge wclk);
      repeat (8) @(posedge rclk);
      #1;
   endtask

   task automatic go_level(input int target, input string tag);
      while (widx - ridx < target) wr_word(1, tag);
      while (widx - ridx > target) rd_word(1, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      wrst_n = 0; rrst_n = 0;
      wr_en = 0; wr_req = 0; wr_data = '0; wr_thr_we = 0; wr_thr_sel = 0; wr_thr_val = '0;
      rd_en = 0; rd_req = 0; rd_mark = 0; rd_release = 0; rd_retx = 0;
      rd_thr_we = 0; rd_thr_sel = 0; rd_thr_val = '0;
      repeat (5) @(posedge wclk);
      @(negedge wclk); wrst_n = 1; rrst_n = 1;
      settle();

      // R1 reset state
      chk("R1 wr_flags", {31'd0, wr_flags}, 36'b00011);
      chk("R1 rd_flags", {31'd0, rd_flags}, 36'b00011);
      chk("R1 wr_ack", {35'd0, wr_ack}, 36'd0);
      chk("R1 rd_ack", {35'd0, rd_ack}, 36'd0);
      chk("R1 rd_data", rd_data, 36'd0);

      // R3 read refused while empty
      rd_word(0, "R3 empty refuse");

      // R4 write request with the enable low
      @(negedge wclk); wr_req = 1; wr_data = pat(999);
      @(posedge wclk); #1; wr_req = 0;
      chk("R4 wr no ack", {35'd0, wr_ack}, 36'd0);
      settle();
      chk("R4 nothing stored", {31'd0, rd_flags}, 36'b00011);

      // R6 crossing latency: first write visible by the fourth rclk edge
      wr_word(1, "R6 write");
      repeat (4) @(posedge rclk); #1;
      chk("R6 rd not empty", {35'd0, rd_flags[0]}, 36'd0);
      rd_word(1, "R6 read");
      settle();

      // R5 table of levels and flags
      for (int k = 0; k < LV_N; k++) begin
         go_level(int'(LV_TAB[k][13:5]), "R5 fill");
         settle();
         chk($sformatf("R5 wr_flags lvl %0d", LV_TAB[k][13:5]), {31'd0, wr_flags}, {31'd0, LV_TAB[k][4:0]});
         chk($sformatf("R5 rd_flags lvl %0d", LV_TAB[k][13:5]), {31'd0, rd_flags}, {31'd0, LV_TAB[k][4:0]});
      end

      // R2 write refused while full; stored words intact
      go_level(256, "R2 fill");
      settle();
      wr_word(0, "R2 full refuse");
      go_level(0, "R2 drain");
      settle();

      // R4 read request with the enable low keeps the position
      go_level(3, "R4 fill");
      settle();
      @(negedge rclk); rd_req = 1;
      @(posedge rclk); #1; rd_req = 0;
      chk("R4 rd no ack", {35'd0, rd_ack}, 36'd0);
      rd_word(1, "R4 position kept");
      go_level(0, "R4 drain");
      settle();

      // R7 programmed thresholds: write AF=16, read AE=20
      @(negedge wclk); wr_thr_we = 1; wr_thr_sel = 1; wr_thr_val = 9'd16;
      @(negedge wclk); wr_thr_we = 0;
      @(negedge rclk); rd_thr_we = 1; rd_thr_sel = 0; rd_thr_val = 9'd20;
      @(negedge rclk); rd_thr_we = 0;
      go_level(20, "R7 fill");
      settle();
      chk("R7 rd AE=20 at 20", {31'd0, rd_flags}, 36'b00010);
      chk("R7 wr AE=8 at 20", {31'd0, wr_flags}, 36'b00000);
      go_level(21, "R7 fill");
      settle();
      chk("R7 rd at 21", {31'd0, rd_flags}, 36'b00000);
      go_level(239, "R7 fill");
      settle();
      chk("R7 wr AF=16 at 239", {31'd0, wr_flags}, 36'b00100);
      go_level(240, "R7 fill");
      settle();
      chk("R7 wr AF=16 at 240", {31'd0, wr_flags}, 36'b01100);
      chk("R7 rd AF=8 at 240", {31'd0, rd_flags}, 36'b00100);
      @(negedge wclk); wr_thr_we = 1; wr_thr_sel = 1; wr_thr_val = 9'd8;
      @(negedge wclk); wr_thr_we = 0;
      go_level(0, "R7 drain");
      settle();

      // R8 and R9 mark, replay, repeat
      go_level(10, "R9 fill");
      settle();
      rd_ctl(0);
      mark_idx = ridx;
      for (int i = 0; i < 5; i++) rd_word(1, "R9 first pass");
      @(negedge rclk); rd_retx = 1; rd_en = 1; rd_req = 1;
      @(posedge rclk); #1; rd_retx = 0; rd_en = 0; rd_req = 0;
      chk("R9 read refused during retx", {35'd0, rd_ack}, 36'd0);
      ridx = mark_idx;
      for (int i = 0; i < 10; i++) rd_word(1, "R9 replay");
      rd_ctl(2);
      ridx = mark_idx;
      for (int i = 0; i < 3; i++) rd_word(1, "R9 second replay");

      while (widx - mark_idx < 256) wr_word(1, "R8 fill to mark");
      settle();
      chk("R8 wr full behind mark", {31'd0, wr_flags}, 36'b11100);
      for (int i = 0; i < 20; i++) rd_word(1, "R8 read past mark");
      settle();
      chk("R8 still full", {31'd0, wr_flags}, 36'b11100);
      wr_word(0, "R8 write refused");

      // R11 release frees the space already read (level 233)
      rd_ctl(1);
      settle();
      chk("R11 wr flags after release", {31'd0, wr_flags}, 36'b00100);
      wr_word(1, "R11 write after release");

      // R10 retransmit without a mark
      rd_ctl(2);
      rd_word(1, "R10 position unchanged");

      go_level(0, "final drain");
      settle();
      chk("R6 both sides empty", {26'd0, wr_flags, rd_flags}, {26'd0, 5'b00011, 5'b00011});

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule